// File: doc/BRIEF.md
# Branch Resolution Unit

This block resolves control flow for a small 64-bit filter processor. Each beat carries one decoded instruction of the jump family: a 3-bit class code, a 4-bit operation code, an operand-select bit, the two register values, the 32-bit immediate, the signed 16-bit displacement and the current program counter. The PC counts 8-byte instruction slots. The unit works out whether the branch is taken and what the next PC is. It also raises a call request that carries the 32-bit call offset, signals program exit, and flags encodings it does not accept.

Instructions arrive on a valid/ready input and results leave on a valid/ready output, one register stage apart. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new beat is taken. The conditional forms compare in full 64-bit width for the wide class and in 32-bit width for the narrow class.

Top module: `bru_unit`

## Requirements
- R1: A beat accepted at edge N shows its result with `out_valid` high after edge N. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs stay stable.
- R2: Operation code 0 is taken unconditionally in both the wide class (3'b101) and the narrow class (3'b110).
- R3: A taken branch gives next PC = PC + 1 + the sign-extended displacement, modulo 2^PCW. A conditional branch that is not taken gives PC + 1.
- R4: `in_src_sel` = 0 compares against the immediate, and `in_src_sel` = 1 compares against `in_src`. In the wide class the immediate is sign-extended to 64 bits.
- R5: Unsigned conditions: 2 is greater, 3 is greater-or-equal, 0xA is less, 0xB is less-or-equal.
- R6: Signed conditions: 6 is greater, 7 is greater-or-equal, 0xC is less, 0xD is less-or-equal.
- R7: Code 1 is taken when the operands are equal, 5 when they are not equal, and 4 when their bitwise AND is nonzero.
- R8: The narrow class compares only bits 31:0 of both operands. Bit 31 is the sign, and the upper register halves are ignored.
- R9: Code 8 in the wide class raises `out_call`, with `out_call_off` equal to the immediate, next PC = PC + 1, and `out_taken` low.
- R10: Code 9 in the wide class raises `out_exit`, and next PC = PC.
- R11: Any class other than 3'b101 or 3'b110, codes 0xE and 0xF, and codes 8 or 9 in the narrow class raise `out_illegal`, with next PC = PC.
- R12: Reset (`rst_n` low, asynchronous) clears `out_valid`.
- R13: At most one of `out_taken`, `out_call`, `out_exit` and `out_illegal` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction beat present |
| in_ready | output | 1 | Unit can take a beat |
| in_class | input | 3 | Class: 3'b101 wide, 3'b110 narrow |
| in_opcode | input | 4 | Operation code |
| in_src_sel | input | 1 | 0 immediate, 1 source register |
| in_dst | input | XLEN | Destination register value |
| in_src | input | XLEN | Source register value |
| in_imm | input | 32 | Immediate / call offset |
| in_off | input | 16 | Signed branch displacement |
| in_pc | input | PCW | Current PC in slots |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_next_pc | output | PCW | Next PC |
| out_taken | output | 1 | Branch taken |
| out_call | output | 1 | Call request |
| out_call_off | output | 32 | Call offset |
| out_exit | output | 1 | Program exit |
| out_illegal | output | 1 | Unsupported encoding |

## Verification
The bench sets up pairs of operands that separate one reading of a condition from another. An all-ones register against 1 tells unsigned from signed order. A value with bit 31 set and the upper half zero tells 32-bit from 64-bit sign handling. An immediate of all ones tells sign extension from zero extension. A design that mixed these up would produce the wrong taken flag and fall through to PC + 1. The bench drives displacements that wrap the PC in both directions, which catch a missing sign extension or a dropped +1. It also drives call and exit in the narrow class, which a careless decoder would execute instead of rejecting. Finally it stalls the output for several cycles while new inputs change, so a unit that overwrote its held result would be caught.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'b101;
  localparam logic [2:0] CLS_NARROW = 3'b110;

  localparam logic [3:0] OP_ALWAYS = 4'h0;
  localparam logic [3:0] OP_EQ     = 4'h1;
  localparam logic [3:0] OP_UGT    = 4'h2;
  localparam logic [3:0] OP_UGE    = 4'h3;
  localparam logic [3:0] OP_BITS   = 4'h4;
  localparam logic [3:0] OP_NE     = 4'h5;
  localparam logic [3:0] OP_SGT    = 4'h6;
  localparam logic [3:0] OP_SGE    = 4'h7;
  localparam logic [3:0] OP_CALL   = 4'h8;
  localparam logic [3:0] OP_EXIT   = 4'h9;
  localparam logic [3:0] OP_ULT    = 4'hA;
  localparam logic [3:0] OP_ULE    = 4'hB;
  localparam logic [3:0] OP_SLT    = 4'hC;
  localparam logic [3:0] OP_SLE    = 4'hD;

  typedef struct packed {
    logic taken;
    logic call;
    logic fin;
    logic bad;
  } bru_flags_t;
endpackage

// File: rtl/bru_operands.sv
module bru_operands #(
  parameter int XLEN = 64,
  parameter int IMMW = 32,
  parameter int NARW = 32
) (
  input  logic            narrow,
  input  logic            src_sel,
  input  logic [XLEN-1:0] dst,
  input  logic [XLEN-1:0] src,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] ua,
  output logic [XLEN-1:0] ub,
  output logic [XLEN-1:0] sa,
  output logic [XLEN-1:0] sb
);
  localparam int IMM_PAD = XLEN - IMMW;
  localparam int NAR_PAD = XLEN - NARW;

  logic [XLEN-1:0] rhs;

  always_comb begin
    rhs = src_sel ? src : {{IMM_PAD{imm[IMMW-1]}}, imm};
    if (narrow) begin
      ua = {{NAR_PAD{1'b0}}, dst[NARW-1:0]};
      ub = {{NAR_PAD{1'b0}}, rhs[NARW-1:0]};
      sa = {{NAR_PAD{dst[NARW-1]}}, dst[NARW-1:0]};
      sb = {{NAR_PAD{rhs[NARW-1]}}, rhs[NARW-1:0]};
    end else begin
      ua = dst;
      ub = rhs;
      sa = dst;
      sb = rhs;
    end
  end
endmodule

// File: rtl/bru_decide.sv
module bru_decide #(
  parameter int XLEN = 64
) (
  input  logic [2:0]      cls,
  input  logic [3:0]      opcode,
  input  logic [XLEN-1:0] ua,
  input  logic [XLEN-1:0] ub,
  input  logic [XLEN-1:0] sa,
  input  logic [XLEN-1:0] sb,
  output bru_pkg::bru_flags_t flags
);
  import bru_pkg::*;

  logic eq, ult, slt, anyb, wide, narrow;

  always_comb begin
    eq     = (ua == ub);
    ult    = (ua < ub);
    slt    = ($signed(sa) < $signed(sb));
    anyb   = |(ua & ub);
    wide   = (cls == CLS_WIDE);
    narrow = (cls == CLS_NARROW);
    flags  = '0;
    if (!wide && !narrow) begin
      flags.bad = 1'b1;
    end else begin
      unique case (opcode)
        OP_ALWAYS: flags.taken = 1'b1;
        OP_EQ:     flags.taken = eq;
        OP_UGT:    flags.taken = !ult && !eq;
        OP_UGE:    flags.taken = !ult;
        OP_BITS:   flags.taken = anyb;
        OP_NE:     flags.taken = !eq;
        OP_SGT:    flags.taken = !slt && !eq;
        OP_SGE:    flags.taken = !slt;
        OP_ULT:    flags.taken = ult;
        OP_ULE:    flags.taken = ult || eq;
        OP_SLT:    flags.taken = slt;
        OP_SLE:    flags.taken = slt || eq;
        OP_CALL: begin
          flags.call = wide;
          flags.bad  = narrow;
        end
        OP_EXIT: begin
          flags.fin = wide;
          flags.bad = narrow;
        end
        default:   flags.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bru_pc_next.sv
module bru_pc_next #(
  parameter int PCW  = 32,
  parameter int OFFW = 16
) (
  input  logic [PCW-1:0]  pc,
  input  logic [OFFW-1:0] off,
  input  logic            taken,
  input  logic            hold,
  output logic [PCW-1:0]  next_pc
);
  localparam int PAD = PCW - OFFW;

  logic [PCW-1:0] seq_pc, disp;

  always_comb begin
    seq_pc = pc + PCW'(1);
    disp   = {{PAD{off[OFFW-1]}}, off};
    if (hold)       next_pc = pc;
    else if (taken) next_pc = seq_pc + disp;
    else            next_pc = seq_pc;
  end
endmodule

// File: rtl/bru_unit.sv
module bru_unit #(
  parameter int XLEN = 64,
  parameter int PCW  = 32,
  parameter int IMMW = 32,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_class,
  input  logic [3:0]      in_opcode,
  input  logic            in_src_sel,
  input  logic [XLEN-1:0] in_dst,
  input  logic [XLEN-1:0] in_src,
  input  logic [IMMW-1:0] in_imm,
  input  logic [OFFW-1:0] in_off,
  input  logic [PCW-1:0]  in_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PCW-1:0]  out_next_pc,
  output logic            out_taken,
  output logic            out_call,
  output logic [IMMW-1:0] out_call_off,
  output logic            out_exit,
  output logic            out_illegal
);
  import bru_pkg::*;

  logic [XLEN-1:0] ua, ub, sa, sb;
  bru_flags_t      flags_d, flags_q;
  logic [PCW-1:0]  next_d;
  logic            accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  bru_operands #(.XLEN(XLEN), .IMMW(IMMW), .NARW(32)) u_ops (
    .narrow (in_class == CLS_NARROW),
    .src_sel(in_src_sel),
    .dst    (in_dst),
    .src    (in_src),
    .imm    (in_imm),
    .ua     (ua),
    .ub     (ub),
    .sa     (sa),
    .sb     (sb)
  );

  bru_decide #(.XLEN(XLEN)) u_dec (
    .cls   (in_class),
    .opcode(in_opcode),
    .ua    (ua),
    .ub    (ub),
    .sa    (sa),
    .sb    (sb),
    .flags (flags_d)
  );

  bru_pc_next #(.PCW(PCW), .OFFW(OFFW)) u_pc (
    .pc     (in_pc),
    .off    (in_off),
    .taken  (flags_d.taken),
    .hold   (flags_d.fin || flags_d.bad),
    .next_pc(next_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      flags_q      <= '0;
      out_next_pc  <= '0;
      out_call_off <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        flags_q      <= flags_d;
        out_next_pc  <= next_d;
        out_call_off <= in_imm;
      end
    end
  end

  assign out_taken   = flags_q.taken;
  assign out_call    = flags_q.call;
  assign out_exit    = flags_q.fin;
  assign out_illegal = flags_q.bad;
endmodule

module bru_unit_chk #(
  parameter int PCW  = 32,
  parameter int IMMW = 32,
  parameter int OFFW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_class,
  input logic [3:0]      in_opcode,
  input logic [IMMW-1:0] in_imm,
  input logic [OFFW-1:0] in_off,
  input logic [PCW-1:0]  in_pc,
  input logic            out_valid,
  input logic            out_ready,
  input logic [PCW-1:0]  out_next_pc,
  input logic            out_taken,
  input logic            out_call,
  input logic [IMMW-1:0] out_call_off,
  input logic            out_exit,
  input logic            out_illegal
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) &&
      $stable({out_taken, out_call, out_exit, out_illegal})));
  // R2
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == 4'h0 && (in_class == 3'b101 || in_class == 3'b110)) |=> out_taken);
  // R3
  taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!out_taken ||
      out_next_pc == PCW'($past(in_pc) + PCW'(1) + {{(PCW-OFFW){$past(in_off[OFFW-1])}}, $past(in_off)})));
  // R3
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_taken || out_exit || out_illegal || out_next_pc == PCW'($past(in_pc) + PCW'(1))));
  // R9
  call_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_class == 3'b101 && in_opcode == 4'h8) |=> (out_call && out_call_off == $past(in_imm)));
  // R10
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_class == 3'b101 && in_opcode == 4'h9) |=> (out_exit && out_next_pc == $past(in_pc)));
  // R11
  narrow_call_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_class == 3'b110 && (in_opcode == 4'h8 || in_opcode == 4'h9)) |=> (out_illegal && !out_call && !out_exit));
  // R13
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_taken, out_call, out_exit, out_illegal}));
endmodule

bind bru_unit bru_unit_chk #(.PCW(PCW), .IMMW(IMMW), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_class(in_class), .in_opcode(in_opcode), .in_imm(in_imm), .in_off(in_off),
  .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
  .out_next_pc(out_next_pc), .out_taken(out_taken), .out_call(out_call),
  .out_call_off(out_call_off), .out_exit(out_exit), .out_illegal(out_illegal)
);

// File: tb/bru_unit_test.sv
module bru_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CW = 3'b101;
  localparam logic [2:0] CN = 3'b110;
  localparam logic [3:0] T = 4'b1000, C = 4'b0100, E = 4'b0010, I = 4'b0001, N = 4'b0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [2:0]  cls;
    logic [3:0]  op;
    logic        sel;
    logic [63:0] dst;
    logic [63:0] src;
    logic [31:0] imm;
    logic [15:0] off;
    logic [31:0] pc;
    logic [31:0] nxt;
    logic [3:0]  fl;
    logic [31:0] coff;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{CW, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd2},      // R2
    '{CN, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'hFFFD, 32'd100, 32'd98, T, 32'd0, 4'd2},    // R2
    '{CW, 4'h1, 1'b0, 64'd7, 64'd0, 32'd7, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd7},      // R7
    '{CW, 4'h1, 1'b0, ONES, 64'd0, 32'hFFFF_FFFF, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd4}, // R4
    '{CW, 4'h1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd4}, // R4
    '{CN, 4'h1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd8}, // R8
    '{CW, 4'h5, 1'b1, 64'd5, 64'd5, 32'd0, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd7},      // R7
    '{CW, 4'h4, 1'b1, 64'h10, 64'h30, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd7},    // R7
    '{CN, 4'h4, 1'b1, 64'h1_0000_0000, 64'h1_0000_0000, 32'd0, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd8}, // R8
    '{CW, 4'h4, 1'b1, 64'h1_0000_0000, 64'h1_0000_0000, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd7}, // R7
    '{CW, 4'h2, 1'b1, ONES, 64'd1, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd5},       // R5
    '{CW, 4'h6, 1'b1, ONES, 64'd1, 32'd0, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd6},       // R6
    '{CW, 4'h3, 1'b1, 64'd9, 64'd9, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd5},      // R5
    '{CW, 4'hA, 1'b1, 64'd3, 64'd4, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd5},      // R5
    '{CW, 4'hB, 1'b1, 64'd5, 64'd4, 32'd0, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd5},      // R5
    '{CW, 4'h7, 1'b1, ONES - 64'd4, ONES - 64'd4, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd6}, // R6
    '{CW, 4'hC, 1'b1, ONES, 64'd0, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd6},       // R6
    '{CW, 4'hD, 1'b1, 64'd2, ONES - 64'd1, 32'd0, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd6}, // R6
    '{CN, 4'h6, 1'b1, 64'h8000_0000, 64'd1, 32'd0, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd8}, // R8
    '{CW, 4'h6, 1'b1, 64'h8000_0000, 64'd1, 32'd0, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd6}, // R6
    '{CN, 4'h2, 1'b1, 64'hFFFF_FFFF_0000_0001, 64'd2, 32'd0, 16'd5, 32'd100, 32'd101, N, 32'd0, 4'd8}, // R8
    '{CW, 4'h8, 1'b0, 64'd0, 64'd0, 32'h1234_5678, 16'd0, 32'd100, 32'd101, C, 32'h1234_5678, 4'd9}, // R9
    '{CW, 4'h9, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 32'd100, 32'd100, E, 32'd0, 4'd10},     // R10
    '{CN, 4'h8, 1'b0, 64'd0, 64'd0, 32'd1, 16'd0, 32'd100, 32'd100, I, 32'd0, 4'd11},     // R11
    '{CN, 4'h9, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 32'd100, 32'd100, I, 32'd0, 4'd11},     // R11
    '{CW, 4'hE, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 32'd100, 32'd100, I, 32'd0, 4'd11},     // R11
    '{3'b100, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 32'd100, 32'd100, I, 32'd0, 4'd11}, // R11
    '{CW, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 32'hFFFF_FFFF, 32'd0, T, 32'd0, 4'd3},  // R3
    '{CW, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'h8000, 32'd0, 32'hFFFF_8001, T, 32'd0, 4'd3}, // R3
    '{CN, 4'hC, 1'b0, 64'h0000_0000_FFFF_FFFE, 64'd0, 32'hFFFF_FFFF, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd8}, // R8
    '{CW, 4'h6, 1'b0, 64'd0, 64'd0, 32'hFFFF_FFFF, 16'd5, 32'd100, 32'd106, T, 32'd0, 4'd4}  // R4
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_src_sel = 1'b0;
  logic [2:0] in_class = '0;
  logic [3:0] in_opcode = '0;
  logic [63:0] in_dst = '0, in_src = '0;
  logic [31:0] in_imm = '0, in_pc = '0;
  logic [15:0] in_off = '0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_next_pc, out_call_off;
  logic out_taken, out_call, out_exit, out_illegal;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bru_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_opcode(in_opcode), .in_src_sel(in_src_sel),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm), .in_off(in_off),
    .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
    .out_next_pc(out_next_pc), .out_taken(out_taken), .out_call(out_call),
    .out_call_off(out_call_off), .out_exit(out_exit), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_class = v.cls; in_opcode = v.op; in_src_sel = v.sel;
    in_dst = v.dst; in_src = v.src; in_imm = v.imm; in_off = v.off; in_pc = v.pc;
    in_valid = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [3:0] fl;
    vec_t v;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(out_valid == 1'b0, "R12", {63'd0, out_valid}, 64'd0);
    check(in_ready == 1'b1, "R1", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      fl = {out_taken, out_call, out_exit, out_illegal};
      check(out_valid && out_next_pc == VEC[i].nxt && fl == VEC[i].fl,
            $sformatf("R%0d vec%0d", VEC[i].req, i),
            {out_valid, 27'd0, fl, out_next_pc}, {1'b1, 27'd0, VEC[i].fl, VEC[i].nxt});
      if (VEC[i].fl == C)
        check(out_call_off == VEC[i].coff, "R9 call offset", {32'd0, out_call_off}, {32'd0, VEC[i].coff});
      // R13: at most one outcome flag
      check($countones(fl) <= 1, "R13", {60'd0, fl}, {60'd0, VEC[i].fl});
    end

    // R1: back-pressure holds result and blocks new beats
    @(negedge clk);
    out_ready = 1'b0;
    drive(VEC[0]);
    @(posedge clk);
    @(negedge clk);
    v = VEC[0];
    v.pc = 32'd200;
    drive(v);
    check(out_valid && !in_ready, "R1 stall", {62'd0, out_valid, in_ready}, 64'd2);
    repeat (3) @(negedge clk);
    check(out_valid && out_next_pc == 32'd106, "R1 hold", {32'd0, out_next_pc}, 64'd106);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_next_pc == 32'd206, "R1 resume", {32'd0, out_next_pc}, 64'd206);

    // R12: reset mid-stream clears a held result
    out_ready = 1'b0;
    drive(VEC[2]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R12 async", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule